// File: doc/BRIEF.md
# Dual-Width Shared Video Memory Bridge

This block lets an 8-bit processor bus and a 16-bit video fetch port share one video memory. The memory is two byte-wide banks placed side by side, so the video port gets a whole word (character byte plus colour byte) in a single access. The processor gets a linear byte space in which a low address bit picks the bank.

The processor reaches the memory through a 32K window at the top of its 16-bit address space. An 8-bit page register, written and read at a fixed processor address outside the window, supplies the upper part of a 23-bit effective byte address. Byte addresses beyond the memory that is built are unmapped.

The two sides share one port per bank. A video request always takes that port. A processor memory access that collides with a video request is held, with `cpu_ready` low, until a cycle with no video request.

Top module: `vmb_bridge`

## Requirements
- R1: During and after reset, `cpu_ready` and `vid_valid` are 0 and the page register reads as 0.
- R2: A processor address whose top bit is 1 falls in the window. Its effective byte address is {page register, cpu_addr[14:0]}. With the default sizes, only effective addresses below 8192 are mapped. An unmapped window access changes no memory and reads 0.
- R3: An even effective byte address selects the character bank, which is bits 7:0 of the video word. An odd one selects the colour bank, bits 15:8 of the same word. The word index is the effective byte address shifted right by one.
- R4: A processor write changes only the byte lane it selects; the other byte of that word keeps its value.
- R5: A processor read of a mapped byte returns that byte on `cpu_rdata` in the cycle `cpu_ready` is 1.
- R6: `vid_valid` is 1 in the cycle after each cycle with `vid_req` high, and `vid_rdata` then holds the 16-bit word at `vid_addr`.
- R7: When a pending processor access to mapped memory meets `vid_req` high, the video read is served and `cpu_ready` stays 0. The processor access is performed at the first clock edge with `vid_req` low, and `cpu_ready` rises one cycle after that edge.
- R8: The page register lives at processor address 0x7FF0. A write loads it, and a read returns it. Either access completes with `cpu_ready` one cycle later, whatever `vid_req` is doing.
- R9: An access to any other address outside the window completes in one cycle. It reads 0 and changes neither memory nor the page register.
- R10: `cpu_ready` is a one-cycle pulse. A request still held in the ready cycle is taken as a new access only from the following cycle.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access-complete pulse; low while the access waits |
| vid_req | input | 1 | Video word read request |
| vid_addr | input | 12 | Video word index |
| vid_rdata | output | 16 | Video word: colour byte high, character byte low |
| vid_valid | output | 1 | `vid_rdata` holds the requested word |

## Verification
The bench first runs a walk of processor writes and reads. It covers even and odd lanes, the last mapped byte, the first unmapped window offset, and an address outside the window. These cases separate lane steering from address truncation: an aliasing design would overwrite byte 0. Video word reads then check that the two lanes land in the correct halves of the word. Single-lane overwrites show that the neighbouring byte survives.

A paged write checks that the page register takes part in the address. Simultaneous processor and video requests show who wins and the exact cycle the processor is released. A request held across the ready pulse separates a one-cycle pulse from a level.

// File: rtl/vmb_pkg.sv
package vmb_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_MEM, TGT_REG} tgt_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_LO, SRC_HI, SRC_REG} rsrc_e;
endpackage

// File: rtl/vmb_decode.sv
module vmb_decode #(
  parameter int CPU_AW = 16,
  parameter int WIN_AW = 15,
  parameter int PAGE_W = 8,
  parameter int MEM_AW = 12,
  parameter logic [CPU_AW-1:0] REG_ADDR = 16'h7FF0
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [PAGE_W-1:0] page,
  output vmb_pkg::tgt_e     tgt,
  output logic [MEM_AW-1:0] word_addr,
  output logic              lane
);
  localparam int EFF_AW  = PAGE_W + WIN_AW;
  localparam int BYTE_AW = MEM_AW + 1;

  logic [EFF_AW-1:0] eff;
  logic win_hit, mapped;

  always_comb begin
    eff       = {page, cpu_addr[WIN_AW-1:0]};
    win_hit   = &cpu_addr[CPU_AW-1:WIN_AW];
    mapped    = (eff[EFF_AW-1:BYTE_AW] == '0);
    lane      = eff[0];
    word_addr = eff[BYTE_AW-1:1];
    if (win_hit)
      tgt = mapped ? vmb_pkg::TGT_MEM : vmb_pkg::TGT_NONE;
    else if (cpu_addr == REG_ADDR)
      tgt = vmb_pkg::TGT_REG;
    else
      tgt = vmb_pkg::TGT_NONE;
  end
endmodule

// File: rtl/vmb_arb.sv
module vmb_arb (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  vmb_pkg::tgt_e  tgt,
  input  logic           lane,
  input  logic           vid_req,
  output logic           grant_mem,
  output logic           page_wr,
  output logic [1:0]     lane_we,
  output logic           cpu_ready,
  output logic           vid_valid,
  output vmb_pkg::rsrc_e src_q
);
  logic pend, grant;

  always_comb begin
    pend      = cpu_req & ~cpu_ready;
    grant     = pend & ((tgt != vmb_pkg::TGT_MEM) | ~vid_req);
    grant_mem = grant & (tgt == vmb_pkg::TGT_MEM);
    page_wr   = grant & cpu_we & (tgt == vmb_pkg::TGT_REG);
    lane_we   = (grant_mem & cpu_we) ? (lane ? 2'b10 : 2'b01) : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b0;
      vid_valid <= 1'b0;
      src_q     <= vmb_pkg::SRC_NONE;
    end else begin
      cpu_ready <= grant;
      vid_valid <= vid_req;
      if (grant) begin
        case (tgt)
          vmb_pkg::TGT_MEM: src_q <= lane ? vmb_pkg::SRC_HI : vmb_pkg::SRC_LO;
          vmb_pkg::TGT_REG: src_q <= vmb_pkg::SRC_REG;
          default:          src_q <= vmb_pkg::SRC_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vmb_byte_ram.sv
module vmb_byte_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/vmb_bridge.sv
module vmb_bridge #(
  parameter int CPU_AW = 16,
  parameter int WIN_AW = 15,
  parameter int PAGE_W = 8,
  parameter int MEM_AW = 12,
  parameter logic [CPU_AW-1:0] REG_ADDR = 16'h7FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  input  logic              vid_req,
  input  logic [MEM_AW-1:0] vid_addr,
  output logic [15:0]       vid_rdata,
  output logic              vid_valid
);
  localparam int LANES = 2;

  logic [PAGE_W-1:0] page_q;
  vmb_pkg::tgt_e     cpu_tgt;
  logic [MEM_AW-1:0] cpu_word;
  logic              cpu_lane;
  logic              grant_mem, page_wr;
  logic [1:0]        ram_we;
  vmb_pkg::rsrc_e    src_q;
  logic [MEM_AW-1:0] port_addr;
  logic              port_en;
  logic [7:0]        ram_q [LANES];

  vmb_decode #(
    .CPU_AW(CPU_AW), .WIN_AW(WIN_AW), .PAGE_W(PAGE_W),
    .MEM_AW(MEM_AW), .REG_ADDR(REG_ADDR)
  ) u_dec (
    .cpu_addr (cpu_addr),
    .page     (page_q),
    .tgt      (cpu_tgt),
    .word_addr(cpu_word),
    .lane     (cpu_lane)
  );

  vmb_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .tgt      (cpu_tgt),
    .lane     (cpu_lane),
    .vid_req  (vid_req),
    .grant_mem(grant_mem),
    .page_wr  (page_wr),
    .lane_we  (ram_we),
    .cpu_ready(cpu_ready),
    .vid_valid(vid_valid),
    .src_q    (src_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          page_q <= '0;
    else if (page_wr) page_q <= cpu_wdata[PAGE_W-1:0];
  end

  always_comb begin
    port_addr = vid_req ? vid_addr : cpu_word;
    port_en   = vid_req | grant_mem;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vmb_byte_ram #(.AW(MEM_AW), .DW(8)) u_ram (
      .clk  (clk),
      .en   (port_en),
      .we   (ram_we[g]),
      .addr (port_addr),
      .wdata(cpu_wdata),
      .rdata(ram_q[g])
    );
  end

  always_comb begin
    vid_rdata = {ram_q[1], ram_q[0]};
    case (src_q)
      vmb_pkg::SRC_LO:  cpu_rdata = ram_q[0];
      vmb_pkg::SRC_HI:  cpu_rdata = ram_q[1];
      vmb_pkg::SRC_REG: cpu_rdata = 8'(page_q);
      default:          cpu_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/vmb_bridge_chk.sv
module vmb_bridge_chk #(
  parameter int CPU_AW = 16,
  parameter logic [CPU_AW-1:0] REG_ADDR = 16'h7FF0
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              vid_req,
  input logic              vid_valid,
  input vmb_pkg::tgt_e     tgt,
  input logic [1:0]        ram_we
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst_q |-> (!cpu_ready && !vid_valid));

  // R6
  a_r6_vid_follows: assert property (@(posedge clk) disable iff (rst)
    vid_req |=> vid_valid);
  a_r6_vid_idle: assert property (@(posedge clk) disable iff (rst)
    !vid_req |=> !vid_valid);

  // R7
  a_r7_video_wins: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_ready && vid_req && tgt == vmb_pkg::TGT_MEM) |=> !cpu_ready);

  // R8
  a_r8_page_fast: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_ready && cpu_addr == REG_ADDR) |=> cpu_ready);

  // R10
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R4
  a_r4_one_lane: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ram_we));
endmodule

bind vmb_bridge vmb_bridge_chk #(.CPU_AW(CPU_AW), .REG_ADDR(REG_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_req  (cpu_req),
  .cpu_addr (cpu_addr),
  .cpu_ready(cpu_ready),
  .vid_req  (vid_req),
  .vid_valid(vid_valid),
  .tgt      (cpu_tgt),
  .ram_we   (ram_we)
);

// File: tb/tb_vmb_bridge.sv
`timescale 1ns/1ps
module tb_vmb_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic        vid_req = 1'b0;
  logic [11:0] vid_addr = '0;
  logic [15:0] vid_rdata;
  logic        vid_valid;

  int n_run = 0, n_fail = 0;
  logic [7:0] rd;
  int nw;

  always #4 clk = ~clk;

  vmb_bridge dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .vid_req(vid_req), .vid_addr(vid_addr),
    .vid_rdata(vid_rdata), .vid_valid(vid_valid)
  );

  // {we, addr[15:0], data[7:0]}: data is write value or expected read value
  localparam logic [24:0] VEC [14] = '{
    {1'b1, 16'h8000, 8'hA5}, {1'b1, 16'h8001, 8'h3C},
    {1'b1, 16'h8002, 8'h11}, {1'b1, 16'h8003, 8'h22},
    {1'b1, 16'h9FFE, 8'h66}, {1'b1, 16'h9FFF, 8'h77},
    {1'b1, 16'hA000, 8'hEE}, {1'b0, 16'h8000, 8'hA5},
    {1'b0, 16'h8001, 8'h3C}, {1'b0, 16'h8003, 8'h22},
    {1'b0, 16'h9FFF, 8'h77}, {1'b0, 16'hA000, 8'h00},
    {1'b0, 16'h1234, 8'h00}, {1'b0, 16'h9FFE, 8'h66}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] r, output int w);
    logic got;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    w = 0; got = 1'b0;
    while (!got) begin
      @(posedge clk); #1;
      if (cpu_ready) got = 1'b1; else w++;
    end
    r = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic vid_rd(input logic [11:0] a, input string req, input logic [15:0] exp);
    @(negedge clk);
    vid_req = 1'b1; vid_addr = a;
    @(posedge clk); #1;
    chk(req, {16'h0, vid_valid, 15'h0}, {16'h0, 1'b1, 15'h0});
    chk(req, {16'h0, vid_rdata}, {16'h0, exp});
    @(negedge clk);
    vid_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", {31'h0, cpu_ready}, 32'h0);
    chk("R1 valid in reset", {31'h0, vid_valid}, 32'h0);
    @(negedge clk); rst = 1'b0;
    cpu_op(1'b0, 16'h7FF0, 8'h00, rd, nw);
    chk("R1 page reads zero", {24'h0, rd}, 32'h0);

    // table walk: R2, R3, R5, R9
    for (int i = 0; i < 14; i++) begin
      cpu_op(VEC[i][24], VEC[i][23:8], VEC[i][7:0], rd, nw);
      if (!VEC[i][24]) chk("R5/R2/R9 table read", {24'h0, rd}, {24'h0, VEC[i][7:0]});
    end

    // R3/R6 word assembly
    vid_rd(12'h000, "R3 word0", 16'h3CA5);
    vid_rd(12'h001, "R3 word1", 16'h2211);
    vid_rd(12'hFFF, "R6 last word", 16'h7766);

    // R4 single-lane overwrite
    cpu_op(1'b1, 16'h8000, 8'h5A, rd, nw);
    vid_rd(12'h000, "R4 low lane only", 16'h3C5A);
    cpu_op(1'b1, 16'h8001, 8'hC3, rd, nw);
    vid_rd(12'h000, "R4 high lane only", 16'hC35A);

    // R8 page register and R2 paging
    cpu_op(1'b1, 16'h7FF0, 8'h01, rd, nw);
    cpu_op(1'b0, 16'h7FF0, 8'h00, rd, nw);
    chk("R8 page readback", {24'h0, rd}, 32'h01);
    cpu_op(1'b1, 16'h8000, 8'h99, rd, nw);
    cpu_op(1'b0, 16'h8000, 8'h00, rd, nw);
    chk("R2 paged unmapped read", {24'h0, rd}, 32'h0);
    cpu_op(1'b1, 16'h7FF0, 8'h00, rd, nw);
    cpu_op(1'b0, 16'h8000, 8'h00, rd, nw);
    chk("R2 page0 data intact", {24'h0, rd}, 32'h5A);

    // R9 write outside window leaves page and memory alone
    cpu_op(1'b1, 16'h1234, 8'hFF, rd, nw);
    cpu_op(1'b0, 16'h7FF0, 8'h00, rd, nw);
    chk("R9 page untouched", {24'h0, rd}, 32'h0);
    vid_rd(12'h000, "R9 memory untouched", 16'hC35A);

    // R8 page access not held by video
    @(negedge clk);
    vid_req = 1'b1; vid_addr = 12'h000;
    cpu_op(1'b1, 16'h7FF0, 8'h00, rd, nw);
    chk("R8 no wait under video", nw, 32'h0);
    @(negedge clk); vid_req = 1'b0;

    // R7 collision
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h8002; cpu_wdata = 8'h44;
    vid_req = 1'b1; vid_addr = 12'h001;
    @(posedge clk); #1;
    chk("R7 cpu held", {31'h0, cpu_ready}, 32'h0);
    chk("R7 video served", {16'h0, vid_rdata}, 32'h2211);
    @(posedge clk); #1;
    chk("R7 cpu still held", {31'h0, cpu_ready}, 32'h0);
    @(negedge clk); vid_req = 1'b0;
    @(posedge clk); #1;
    chk("R7 cpu released", {31'h0, cpu_ready}, 32'h1);
    @(negedge clk); cpu_req = 1'b0;
    vid_rd(12'h001, "R4/R7 write landed", 16'h2244);

    // R10 held request
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h7FF0;
    @(posedge clk); #1;
    chk("R10 first ready", {31'h0, cpu_ready}, 32'h1);
    @(posedge clk); #1;
    chk("R10 pulse drops", {31'h0, cpu_ready}, 32'h0);
    @(posedge clk); #1;
    chk("R10 reissue", {31'h0, cpu_ready}, 32'h1);
    @(negedge clk); cpu_req = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule